// File: doc/BRIEF.md
# Modulus Counter with Prescaler

The block is a 16-bit up-counter that serves as a shared time base for neighbouring capture and compare channels, which read its current value from `count_out`. Each step of the counter is triggered by a tick. A 2-bit control field selects where ticks come from: nothing, a rising or falling edge on an external clock pin, or an internal 8-bit prescaler running on the system clock. When the counter steps past its all-ones value, it reloads from a software-written modulus latch and raises a one-clock overflow pulse.

The prescaler holds a twos-complement reload value and counts up from it, so the value `256 - N` divides by N. A new reload value written while the prescaler is already selected only takes effect at the prescaler's next overflow. Switching the clock source to the prescaler copies the written value into the prescaler at once. A second external pin can force an immediate reload from the modulus latch on a rising edge, a falling edge or both edges. A freeze input, honoured only while its enable bit is set, holds the counter and the prescaler. Both pins pass through a two-flop synchronizer, and their synchronized levels can be read back.

Control and status use plain write-enable strobes and always-valid read buses. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `modctr_top`

## Requirements
- R1: After reset, `ctrl_rdata`, `latch_rdata` and `count_out` read zero and `ovf_pulse` is low.
- R2: Control bits [9:8] select the tick source. 00 gives no ticks, 01 counts falling edges of `clk_pin`, 10 counts rising edges of `clk_pin`, and 11 counts prescaler ticks. A pin edge moves `count_out` on the third rising clock edge after the pin changes.
- R3: With prescaler value v in control bits [7:0], the counter steps once every 256 - v system clocks. The value 0 means 256.
- R4: A control write that changes the source to 11 from another source loads the written prescaler value at once. A write made while the source is already 11 takes effect only after the current prescaler period ends.
- R5: A tick that finds `count_out` at 0xFFFF reloads `count_out` from the modulus latch and sets `ovf_pulse` high for exactly one clock.
- R6: Control bits [11:10] set the load-pin sensitivity. 00 means no loads, 01 loads on rising edges, 10 on falling edges, and 11 on both edges. A load copies the modulus latch into `count_out`.
- R7: If a load-pin edge and a count tick fall in the same clock, the counter takes the latch value, does not increment, and gives no overflow pulse.
- R8: When control bit 12 is set and `freeze_in` is high, the counter holds its value and ignores both ticks and pin loads. When bit 12 is clear, `freeze_in` has no effect.
- R9: `ctrl_rdata[13]` and `ctrl_rdata[14]` show the synchronized levels of `clk_pin` and `load_pin`. Each follows its pin two clocks after the pin changes.
- R10: `latch_rdata` returns the last value written to the modulus latch. With a latch of zero, a reload restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_in | input | 1 | External freeze request |
| clk_pin | input | 1 | External count clock pin (asynchronous) |
| load_pin | input | 1 | External load pin (asynchronous) |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 13 | Control write data: [7:0] prescaler, [9:8] source, [11:10] load edges, [12] freeze enable |
| latch_we | input | 1 | Modulus latch write strobe |
| latch_wdata | input | 16 | Modulus latch write data |
| ctrl_rdata | output | 15 | Control fields in [12:0], clock pin level in [13], load pin level in [14] |
| latch_rdata | output | 16 | Modulus latch contents |
| count_out | output | 16 | Current counter value |
| ovf_pulse | output | 1 | One-clock pulse on counter wrap |

## Verification
The bench sweeps a range of prescaler values. For each one it measures the first and second intervals between counter steps. A design that ignored the immediate load on source selection would start with a 256-clock interval, and an off-by-one divider would miss by one clock. A rewrite during a running period checks that the new value waits for the prescaler overflow; an eager reload would shift the first step earlier. The remaining tests cover wrap and reload from a latch changed after the counter was loaded, a load edge that coincides with a count edge (a wrong priority gives latch+1), freeze with the enable bit both set and clear, and every edge-sensitivity code, each checked at the cycle the synchronizer latency predicts.

// File: rtl/modctr_pkg.sv
package modctr_pkg;
  localparam int PSC_W = 8;

  typedef enum logic [1:0] {
    CS_OFF       = 2'b00,
    CS_PIN_FALL  = 2'b01,
    CS_PIN_RISE  = 2'b10,
    CS_PRESC     = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    LE_OFF  = 2'b00,
    LE_RISE = 2'b01,
    LE_FALL = 2'b10,
    LE_BOTH = 2'b11
  } load_edge_e;

  typedef struct packed {
    logic               fren;
    load_edge_e         edg;
    clk_sel_e           sel;
    logic [PSC_W-1:0]   psc;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int RD_W   = CTRL_W + 2;
endpackage

// File: rtl/modctr_edge_sync.sv
module modctr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its one-clock-old copy
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/modctr_prescaler.sv
module modctr_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         start_load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic         tick
);
  logic [W-1:0] pcnt;

  assign tick = run & (&pcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pcnt <= '0;
    else if (start_load) pcnt <= load_val;
    else if (run) begin
      if (&pcnt) pcnt <= reload_val;
      else       pcnt <= pcnt + 1'b1;
    end
  end

  // R4: after an overflow the prescaler restarts from the stored reload value
  a_r4_reload_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start_load) |=> (pcnt == $past(reload_val)));
endmodule

// File: rtl/modctr_counter.sv
module modctr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frozen,
  input  logic         tick,
  input  logic         pin_load,
  input  logic [W-1:0] latch,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (!frozen) begin
        if (pin_load) cnt <= latch;
        else if (tick) begin
          if (&cnt) begin
            cnt <= latch;
            ovf <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (cnt == $past(cnt)));

  a_r7_pin_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && pin_load) |=> (cnt == $past(latch) && !ovf));

  a_r5_ovf_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt == $past(latch)));

  a_r2_no_source_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pin_load) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/modctr_top.sv
module modctr_top
  import modctr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_in,
  input  logic              clk_pin,
  input  logic              load_pin,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              latch_we,
  input  logic [CNT_W-1:0]  latch_wdata,
  output logic [RD_W-1:0]   ctrl_rdata,
  output logic [CNT_W-1:0]  latch_rdata,
  output logic [CNT_W-1:0]  count_out,
  output logic              ovf_pulse
);
  ctrl_t            ctrl_q;
  ctrl_t            wr;
  logic [CNT_W-1:0] latch_q;
  logic             cp_lvl, cp_rise, cp_fall;
  logic             lp_lvl, lp_rise, lp_fall;
  logic             frozen, src_tick, psc_tick, pin_load, start_load, psc_run;

  assign wr = ctrl_t'(ctrl_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      latch_q <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= wr;
      if (latch_we) latch_q <= latch_wdata;
    end
  end

  modctr_edge_sync #(.STAGES(SYNC_STAGES)) u_cp_sync (
    .clk(clk), .rst_n(rst_n), .pin(clk_pin),
    .level(cp_lvl), .rise(cp_rise), .fall(cp_fall));

  modctr_edge_sync #(.STAGES(SYNC_STAGES)) u_lp_sync (
    .clk(clk), .rst_n(rst_n), .pin(load_pin),
    .level(lp_lvl), .rise(lp_rise), .fall(lp_fall));

  assign frozen     = ctrl_q.fren & freeze_in;
  assign psc_run    = (ctrl_q.sel == CS_PRESC) & ~frozen;
  assign start_load = ctrl_we & (wr.sel == CS_PRESC) & (ctrl_q.sel != CS_PRESC);

  modctr_prescaler #(.W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(psc_run), .start_load(start_load),
    .load_val(wr.psc), .reload_val(ctrl_q.psc), .tick(psc_tick));

  always_comb begin
    unique case (ctrl_q.sel)
      CS_PIN_FALL: src_tick = cp_fall;
      CS_PIN_RISE: src_tick = cp_rise;
      CS_PRESC:    src_tick = psc_tick;
      default:     src_tick = 1'b0;
    endcase
    unique case (ctrl_q.edg)
      LE_RISE: pin_load = lp_rise;
      LE_FALL: pin_load = lp_fall;
      LE_BOTH: pin_load = lp_rise | lp_fall;
      default: pin_load = 1'b0;
    endcase
  end

  modctr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .tick(src_tick),
    .pin_load(pin_load), .latch(latch_q), .cnt(count_out), .ovf(ovf_pulse));

  assign ctrl_rdata  = {lp_lvl, cp_lvl, ctrl_q};
  assign latch_rdata = latch_q;
endmodule

// File: tb/modctr_top_tb_top.sv
module modctr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze_in = 1'b0, clk_pin = 1'b0, load_pin = 1'b0;
  logic        ctrl_we = 1'b0, latch_we = 1'b0;
  logic [12:0] ctrl_wdata = '0;
  logic [15:0] latch_wdata = '0;
  logic [14:0] ctrl_rdata;
  logic [15:0] latch_rdata, count_out;
  logic        ovf_pulse;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modctr_top dut_i (
    .clk(clk), .rst_n(rst_n), .freeze_in(freeze_in), .clk_pin(clk_pin),
    .load_pin(load_pin), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .latch_we(latch_we), .latch_wdata(latch_wdata), .ctrl_rdata(ctrl_rdata),
    .latch_rdata(latch_rdata), .count_out(count_out), .ovf_pulse(ovf_pulse));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clk_pin = 1'b0; load_pin = 1'b0; freeze_in = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  // control word: fren[12], edg[11:10], sel[9:8], psc[7:0]
  task automatic wr_ctrl(input bit fren, input logic [1:0] edg, input logic [1:0] sel,
                         input logic [7:0] psc);
    ctrl_wdata = {fren, edg, sel, psc};
    ctrl_we = 1'b1;
    step(1);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_latch(input logic [15:0] v);
    latch_wdata = v;
    latch_we = 1'b1;
    step(1);
    latch_we = 1'b0;
  endtask

  task automatic set_clk(input logic v);
    clk_pin = v; step(3);
  endtask

  task automatic set_load(input logic v);
    load_pin = v; step(3);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(ctrl_rdata == 0, "R1 ctrl", ctrl_rdata, 0);
    check(latch_rdata == 0, "R1 latch", latch_rdata, 0);
    check(count_out == 0 && !ovf_pulse, "R1 count", count_out, 0);

    // R3: sweep prescaler values, first and second step intervals
    for (int v = 240; v <= 257; v++) begin
      logic [7:0] pv;
      int first, second, exp_ratio;
      pv = (v == 256) ? 8'h00 : (v == 257) ? 8'h80 : 8'(v);
      exp_ratio = 256 - int'(pv);
      do_reset();
      wr_ctrl(1'b0, 2'b00, 2'b11, pv);
      first = -1; second = -1;
      for (int k = 1; k <= 2 * exp_ratio + 2; k++) begin
        step(1);
        if (first < 0 && count_out == 1) first = k;
        if (second < 0 && count_out == 2) second = k;
      end
      check(first == exp_ratio, "R3 first interval", first, exp_ratio);
      check(second == 2 * exp_ratio, "R3 second interval", second, 2 * exp_ratio);
    end

    // R4: rewrite while prescaler selected waits for overflow
    do_reset();
    wr_ctrl(1'b0, 2'b00, 2'b11, 8'hFC);
    wr_ctrl(1'b0, 2'b00, 2'b11, 8'hFE);
    step(2);
    check(count_out == 0, "R4 deferred early", count_out, 0);
    step(1);
    check(count_out == 1, "R4 deferred first", count_out, 1);
    step(2);
    check(count_out == 2, "R4 new ratio", count_out, 2);

    // R2: source 00 ignores pin, 10 rising, 01 falling
    do_reset();
    wr_ctrl(1'b0, 2'b00, 2'b00, 8'h00);
    set_clk(1); set_clk(0);
    check(count_out == 0, "R2 source off", count_out, 0);
    wr_ctrl(1'b0, 2'b00, 2'b10, 8'h00);
    clk_pin = 1'b1; step(2);
    check(count_out == 0, "R2 rising latency", count_out, 0);
    step(1);
    check(count_out == 1, "R2 rising", count_out, 1);
    set_clk(0);
    check(count_out == 1, "R2 rising ignores fall", count_out, 1);
    wr_ctrl(1'b0, 2'b00, 2'b01, 8'h00);
    set_clk(1);
    check(count_out == 1, "R2 falling ignores rise", count_out, 1);
    set_clk(0);
    check(count_out == 2, "R2 falling", count_out, 2);

    // R9 status levels
    clk_pin = 1'b1; load_pin = 1'b1; step(1);
    check(ctrl_rdata[14:13] == 2'b00, "R9 sync latency", ctrl_rdata[14:13], 0);
    step(1);
    check(ctrl_rdata[14:13] == 2'b11, "R9 levels high", ctrl_rdata[14:13], 3);
    clk_pin = 1'b0; load_pin = 1'b0; step(2);
    check(ctrl_rdata[14:13] == 2'b00, "R9 levels low", ctrl_rdata[14:13], 0);

    // R6 load edge codes
    do_reset();
    wr_latch(16'h0055);
    check(latch_rdata == 16'h0055, "R10 latch readback", latch_rdata, 16'h55);
    wr_ctrl(1'b0, 2'b00, 2'b00, 8'h00);
    set_load(1); set_load(0);
    check(count_out == 0, "R6 loads off", count_out, 0);
    wr_ctrl(1'b0, 2'b01, 2'b00, 8'h00);
    set_load(1);
    check(count_out == 16'h55, "R6 rising load", count_out, 16'h55);
    wr_latch(16'h0066);
    set_load(0);
    check(count_out == 16'h55, "R6 rising ignores fall", count_out, 16'h55);
    wr_ctrl(1'b0, 2'b10, 2'b00, 8'h00);
    set_load(1);
    check(count_out == 16'h55, "R6 falling ignores rise", count_out, 16'h55);
    set_load(0);
    check(count_out == 16'h66, "R6 falling load", count_out, 16'h66);
    wr_latch(16'h0077);
    wr_ctrl(1'b0, 2'b11, 2'b00, 8'h00);
    set_load(1);
    check(count_out == 16'h77, "R6 both rise", count_out, 16'h77);
    wr_latch(16'h0088);
    set_load(0);
    check(count_out == 16'h88, "R6 both fall", count_out, 16'h88);

    // R5 wrap reloads from latch with one-clock pulse
    do_reset();
    wr_latch(16'hFFFE);
    wr_ctrl(1'b0, 2'b01, 2'b10, 8'h00);
    set_load(1);
    check(count_out == 16'hFFFE, "R5 preload", count_out, 16'hFFFE);
    wr_latch(16'h1234);
    set_clk(1); set_clk(0);
    check(count_out == 16'hFFFF && !ovf_pulse, "R5 at top", count_out, 16'hFFFF);
    set_clk(1);
    check(count_out == 16'h1234, "R5 wrap reload", count_out, 16'h1234);
    check(ovf_pulse == 1'b1, "R5 pulse high", ovf_pulse, 1);
    step(1);
    check(ovf_pulse == 1'b0, "R5 pulse one clock", ovf_pulse, 0);

    // R7 load wins over simultaneous tick
    set_clk(0); set_load(0);
    wr_latch(16'h0100);
    clk_pin = 1'b1; load_pin = 1'b1; step(3);
    check(count_out == 16'h0100, "R7 load beats tick", count_out, 16'h100);
    check(ovf_pulse == 1'b0, "R7 no pulse", ovf_pulse, 0);
    clk_pin = 1'b0; load_pin = 1'b0; step(3);

    // R8 freeze
    wr_ctrl(1'b1, 2'b01, 2'b10, 8'h00);
    freeze_in = 1'b1;
    set_clk(1); set_clk(0);
    wr_latch(16'h0200);
    set_load(1); set_load(0);
    check(count_out == 16'h0100, "R8 frozen hold", count_out, 16'h100);
    wr_ctrl(1'b0, 2'b01, 2'b10, 8'h00);
    set_clk(1);
    check(count_out == 16'h0101, "R8 freeze ignored without enable", count_out, 16'h101);
    freeze_in = 1'b0;

    // R10 zero latch restarts from zero
    set_clk(0);
    wr_latch(16'h0000);
    set_load(1);
    check(count_out == 0, "R10 zero restart", count_out, 0);
    set_clk(1);
    check(count_out == 1, "R10 counts from zero", count_out, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule